// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block generates the digital drive pattern for a four-common, sixteen-segment multiplexed LCD panel, which gives up to 64 pixels. A register file holds one 16-bit segment row for each common. A scan sequencer steps through the frame. For every common pin and every segment pin it then outputs a 2-bit code that selects a voltage level. An external resistor ladder and analog buffers turn these codes into real voltages.

Each common owns one slot of the frame. Each slot is split into two half-phases of opposite polarity, so every pixel sees zero net DC. Two bias schemes are available. The third-bias scheme runs at twice the frame rate of the half-bias scheme. Until software turns the display on, and again after a restart pulse (for example on leaving clock-stop), every pin carries non-select waveforms. A panel-off bit hands every LCD pin back to the general I/O function. Segment pins S5 to S16 can also be returned to I/O one at a time.

A prescaler supplies one tick per step. The CPU side writes registers through a single-cycle write port.

Top module: `lcd_mux_drive`

## Requirements
- R1: After reset the display is off, half-bias is selected, panel-off is 0, S5–S16 are given to I/O (seg_en_o = 16'h000F), and the outputs show phase 0 of the non-select pattern: every common code is 01 and every enabled segment code is 11.
- R2: The frame is 8 half-phases. Common n is selected during half-phases 2n and 2n+1. A selected common drives 11 in its first half-phase and 00 in its second. At most one common drives 11 at any time.
- R3: With third-bias (control bit 1 = 1), level codes are 00 = ground, 01 = 1/3, 10 = 2/3, 11 = full. A non-selected common drives 01 then 10. A lit segment drives 00 then 11. A dark segment drives 10 then 01.
- R4: With half-bias, a non-selected common drives 01 (half level) in both half-phases. A lit segment drives 00 then 11. A dark segment drives 11 then 00, so segments never use 01 or 10.
- R5: With third-bias the scan advances one half-phase per tick_i (8 ticks per frame). With half-bias it advances on every second tick (16 ticks per frame).
- R6: The display-on bit (address 4, bit 0) is sampled at the start of each slot. While the sampled value is 0, all commons are non-selected and all segments are dark.
- R7: The segment row for a common (address n, bit j = segment S(j+1)) is sampled at the start of that common's slot. A write during a slot does not change the outputs of that slot.
- R8: While panel-off (address 4, bit 2) is 1, every com_en_o and seg_en_o bit is 0 and every level code is 00. While it is 0, the commons and S1–S4 are enabled.
- R9: Address 5 bit j selects S(j+1) as a segment output (1) or an I/O pin (0) for j ≥ 4. Bits 3:0 of that register have no effect. A pin given to I/O drives code 00.
- R10: A restart_i pulse clears the display-on bit, returns the scan to half-phase 0 and loads the bias selection at once.
- R11: A change of the bias bit takes effect only at the start of the next frame (on the step from half-phase 7 to 0) or at a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Step pulse from the prescaler |
| restart_i | input | 1 | Resynchronise scan, display off |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | 0–3 rows, 4 control, 5 pin select |
| wr_data_i | input | 16 | Write data |
| com_lvl_o | output | 8 | Level code of common n at [2n+1:2n] |
| seg_lvl_o | output | 32 | Level code of segment S(j+1) at [2j+1:2j] |
| com_en_o | output | 4 | Common pin is an LCD output |
| seg_en_o | output | 16 | Segment pin is an LCD output |

## Verification
The main function is tried with a set of segment patterns: all lit, all dark, alternating bits, a walking lit pixel, and rows that differ per common. Each pattern runs under both bias schemes. Together these separate a polarity swap from a slot-to-common mix-up, and a lit code from a dark code in each level set. Comparing whole frames at half-bias against third-bias shows whether the tick divider and the third-bias level set are right. Directed sequences write in the middle of a slot, toggle the display and bias bits within a frame, and alternate the pin masks. These show that each control is sampled at the boundary where it is meant to be sampled.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_GND  = 2'b00;
  localparam lvl_t LVL_LO   = 2'b01;
  localparam lvl_t LVL_HI   = 2'b10;
  localparam lvl_t LVL_FULL = 2'b11;
endpackage

// File: rtl/lcd_ctrl_regs.sv
module lcd_ctrl_regs #(
  parameter int NUM_COM   = 4,
  parameter int NUM_SEG   = 16,
  parameter int FIXED_SEG = 4,
  parameter int AW        = $clog2(NUM_COM + 2)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             restart_i,
  input  logic                             wr_en_i,
  input  logic [AW-1:0]                    wr_addr_i,
  input  logic [NUM_SEG-1:0]               wr_data_i,
  output logic [NUM_COM-1:0][NUM_SEG-1:0]  rows_o,
  output logic                             disp_on_o,
  output logic                             bias_third_o,
  output logic                             panel_off_o,
  output logic [NUM_SEG-1:0]               pin_sel_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NUM_COM);
  localparam logic [AW-1:0] SEL_ADDR  = AW'(NUM_COM + 1);

  for (genvar c = 0; c < NUM_COM; c++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rows_o[c] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(c)) rows_o[c] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_on_o    <= 1'b0;
      bias_third_o <= 1'b0;
      panel_off_o  <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == CTRL_ADDR) begin
        bias_third_o <= wr_data_i[1];
        panel_off_o  <= wr_data_i[2];
      end
      if (restart_i)
        disp_on_o <= 1'b0;
      else if (wr_en_i && wr_addr_i == CTRL_ADDR)
        disp_on_o <= wr_data_i[0];
    end
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_sel
    if (j < FIXED_SEG) begin : g_fixed
      assign pin_sel_o[j] = 1'b1;
    end else begin : g_prog
      logic sel_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sel_q <= 1'b0;
        else if (wr_en_i && wr_addr_i == SEL_ADDR) sel_q <= wr_data_i[j];
      end
      assign pin_sel_o[j] = sel_q;
    end
  end

  assert_restart_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !disp_on_o);
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 16,
  parameter int SW      = $clog2(NUM_COM),
  parameter int PW      = SW + 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             tick_i,
  input  logic                             restart_i,
  input  logic [NUM_COM-1:0][NUM_SEG-1:0]  rows_i,
  input  logic                             disp_on_i,
  input  logic                             bias_third_i,
  output logic [PW-1:0]                    phase_o,
  output logic [NUM_SEG-1:0]               row_o,
  output logic                             on_o,
  output logic                             third_o
);
  localparam logic [PW-1:0] LAST = {PW{1'b1}};

  logic          div_q;
  logic          step;
  logic [SW-1:0] next_slot;

  // half-bias runs at half the step rate
  assign step      = tick_i && (third_o || div_q);
  assign next_slot = phase_o[PW-1:1] + SW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      div_q   <= 1'b0;
      third_o <= 1'b0;
      on_o    <= 1'b0;
      row_o   <= '0;
    end else if (restart_i) begin
      phase_o <= '0;
      div_q   <= 1'b0;
      third_o <= bias_third_i;
      on_o    <= 1'b0;
      row_o   <= '0;
    end else if (tick_i) begin
      div_q <= third_o ? 1'b0 : !div_q;
      if (step) begin
        phase_o <= phase_o + PW'(1);
        if (phase_o[0]) begin
          on_o  <= disp_on_i;
          row_o <= rows_i[next_slot];
        end
        if (phase_o == LAST) third_o <= bias_third_i;
      end
    end
  end

  assert_half_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !restart_i && !third_o && !div_q) |=> $stable(phase_o));
  assert_third_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !restart_i && third_o) |=> (phase_o != $past(phase_o)));
endmodule

// File: rtl/lcd_wave.sv
module lcd_wave
  import lcd_mux_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 16,
  parameter int SW      = $clog2(NUM_COM),
  parameter int PW      = SW + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PW-1:0]          phase_i,
  input  logic [NUM_SEG-1:0]     row_i,
  input  logic                   on_i,
  input  logic                   third_i,
  input  logic                   panel_off_i,
  input  logic [NUM_SEG-1:0]     pin_sel_i,
  output logic [2*NUM_COM-1:0]   com_lvl_o,
  output logic [2*NUM_SEG-1:0]   seg_lvl_o,
  output logic [NUM_COM-1:0]     com_en_o,
  output logic [NUM_SEG-1:0]     seg_en_o
);
  logic          pol;
  logic [SW-1:0] slot;
  logic [NUM_COM-1:0] com_full;
  logic [NUM_COM-1:0] com_mid;

  assign pol  = phase_i[0];
  assign slot = phase_i[PW-1:1];

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    logic sel;
    lvl_t code;
    assign sel = on_i && (slot == SW'(c));
    always_comb begin
      if (sel)          code = pol ? LVL_GND : LVL_FULL;
      else if (third_i) code = pol ? LVL_HI  : LVL_LO;
      else              code = LVL_LO;
    end
    assign com_en_o[c]        = !panel_off_i;
    assign com_lvl_o[2*c +: 2] = com_en_o[c] ? code : LVL_GND;
    assign com_full[c] = (com_lvl_o[2*c +: 2] == LVL_FULL);
    assign com_mid[c]  = (com_lvl_o[2*c +: 2] == LVL_LO) || (com_lvl_o[2*c +: 2] == LVL_HI);
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    logic dot;
    lvl_t code;
    assign dot = on_i && row_i[j];
    always_comb begin
      if (dot)          code = pol ? LVL_FULL : LVL_GND;
      else if (third_i) code = pol ? LVL_LO   : LVL_HI;
      else              code = pol ? LVL_GND  : LVL_FULL;
    end
    assign seg_en_o[j]         = !panel_off_i && pin_sel_i[j];
    assign seg_lvl_o[2*j +: 2] = seg_en_o[j] ? code : LVL_GND;
  end

  assert_one_selected_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(com_full));
  assert_off_nonselect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_i && !panel_off_i) |-> (com_mid == {NUM_COM{1'b1}}));
endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive #(
  parameter int NUM_COM   = 4,
  parameter int NUM_SEG   = 16,
  parameter int FIXED_SEG = 4,
  parameter int AW        = $clog2(NUM_COM + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  restart_i,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [NUM_SEG-1:0]    wr_data_i,
  output logic [2*NUM_COM-1:0]  com_lvl_o,
  output logic [2*NUM_SEG-1:0]  seg_lvl_o,
  output logic [NUM_COM-1:0]    com_en_o,
  output logic [NUM_SEG-1:0]    seg_en_o
);
  localparam int SW = $clog2(NUM_COM);
  localparam int PW = SW + 1;

  logic [NUM_COM-1:0][NUM_SEG-1:0] rows;
  logic                            disp_on, bias_third, panel_off;
  logic [NUM_SEG-1:0]              pin_sel;
  logic [PW-1:0]                   phase;
  logic [NUM_SEG-1:0]              row_act;
  logic                            on_act, third_act;

  lcd_ctrl_regs #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .FIXED_SEG(FIXED_SEG), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .restart_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rows_o(rows), .disp_on_o(disp_on), .bias_third_o(bias_third),
    .panel_off_o(panel_off), .pin_sel_o(pin_sel)
  );

  lcd_scan #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .SW(SW), .PW(PW)) u_scan (
    .clk_i, .rst_ni, .tick_i, .restart_i, .rows_i(rows), .disp_on_i(disp_on),
    .bias_third_i(bias_third), .phase_o(phase), .row_o(row_act),
    .on_o(on_act), .third_o(third_act)
  );

  lcd_wave #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .SW(SW), .PW(PW)) u_wave (
    .clk_i, .rst_ni, .phase_i(phase), .row_i(row_act), .on_i(on_act),
    .third_i(third_act), .panel_off_i(panel_off), .pin_sel_i(pin_sel),
    .com_lvl_o, .seg_lvl_o, .com_en_o, .seg_en_o
  );

  assert_panel_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_off |-> (com_en_o == '0 && seg_en_o == '0 && seg_lvl_o == '0));
endmodule

// File: tb/sim_lcd_mux_drive.sv
module sim_lcd_mux_drive;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, restart = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  com_lvl;
  logic [31:0] seg_lvl;
  logic [3:0]  com_en;
  logic [15:0] seg_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mux_drive u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .restart_i(restart),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .com_lvl_o(com_lvl), .seg_lvl_o(seg_lvl), .com_en_o(com_en), .seg_en_o(seg_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // register shadow and behavioural scan model built from the requirements
  logic [15:0] b_rows [4];
  logic b_on = 0, b_third = 0, b_off = 0;
  logic [15:0] b_sel = 16'h000F;
  logic [2:0]  m_phase = '0;
  logic m_div = 0, m_third = 0, m_on = 0;
  logic [15:0] m_row = '0;

  // {third, row0, row1, row2, row3}
  localparam logic [64:0] VECS [0:5] = '{
    {1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000},
    {1'b1, 16'hA5A5, 16'h5A5A, 16'h0F0F, 16'hF0F0},
    {1'b0, 16'h0001, 16'h0010, 16'h0100, 16'h1000},
    {1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {1'b0, 16'h1234, 16'h8001, 16'hCAFE, 16'h7FFE}
  };

  function automatic logic [1:0] com_code(bit sel, bit pol, bit third);
    if (sel)   return pol ? 2'b00 : 2'b11;
    if (third) return pol ? 2'b10 : 2'b01;
    return 2'b01;
  endfunction

  function automatic logic [1:0] seg_code(bit dot, bit pol, bit third);
    if (dot)   return pol ? 2'b11 : 2'b00;
    if (third) return pol ? 2'b01 : 2'b10;
    return pol ? 2'b00 : 2'b11;
  endfunction

  task automatic check(string tag);
    logic [7:0] ec; logic [31:0] es; logic [3:0] ece; logic [15:0] ese;
    for (int i = 0; i < 4; i++) begin
      ece[i] = !b_off;
      ec[2*i +: 2] = ece[i] ? com_code(m_on && m_phase[2:1] == i, m_phase[0], m_third) : 2'b00;
    end
    for (int j = 0; j < 16; j++) begin
      ese[j] = !b_off && b_sel[j];
      es[2*j +: 2] = ese[j] ? seg_code(m_on && m_row[j], m_phase[0], m_third) : 2'b00;
    end
    n_chk++;
    if (com_lvl !== ec || seg_lvl !== es || com_en !== ece || seg_en !== ese) begin
      n_fail++;
      $display("FAIL %s: com %h/%h seg %h/%h com_en %h/%h seg_en %h/%h (actual/expected)",
               tag, com_lvl, ec, seg_lvl, es, com_en, ece, seg_en, ese);
    end
  endtask

  task automatic check_lit(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_reg(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 3'd4) b_rows[a[1:0]] = d;
    else if (a == 3'd4) begin b_on = d[0]; b_third = d[1]; b_off = d[2]; end
    else if (a == 3'd5) b_sel = {d[15:4], 4'hF};
  endtask

  task automatic do_tick();
    logic step;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    step = m_third || m_div;
    m_div = m_third ? 1'b0 : !m_div;
    if (step) begin
      if (m_phase[0]) begin
        m_on = b_on;
        m_row = b_rows[2'(m_phase[2:1] + 2'd1)];
      end
      if (m_phase == 3'd7) m_third = b_third;
      m_phase = m_phase + 3'd1;
    end
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    m_phase = '0; m_div = 0; m_third = b_third; m_on = 0; m_row = '0; b_on = 0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0; logic [31:0] s0;
    for (int i = 0; i < 4; i++) b_rows[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, literal codes
    check_lit("R1 com", {56'd0, com_lvl}, {56'd0, 8'h55});
    check_lit("R1 seg", {32'd0, seg_lvl}, {32'd0, 32'h000000FF});
    check_lit("R1 en", {44'd0, com_en, seg_en}, {44'd0, 4'hF, 16'h000F});
    check("R1 model");

    // vector table: R2 R3 R4 per pattern
    write_reg(3'd5, 16'hFFFF);
    for (int v = 0; v < 6; v++) begin
      logic [64:0] e;
      e = VECS[v];
      for (int r = 0; r < 4; r++) write_reg(3'(r), e[63-16*r -: 16]);
      write_reg(3'd4, {14'd0, e[64], 1'b0});
      do_restart();
      write_reg(3'd4, {14'd0, e[64], 1'b1});
      for (int t = 0; t < (e[64] ? 16 : 32); t++) begin
        do_tick();
        check(e[64] ? "R2 R3 pattern" : "R2 R4 pattern");
      end
    end

    // R5: half-bias needs two ticks per half-phase
    write_reg(3'd4, 16'h0000);
    do_restart();
    c0 = com_lvl; s0 = seg_lvl;
    do_tick();
    check_lit("R5 half hold", {seg_lvl, 24'd0, com_lvl}, {s0, 24'd0, c0});
    do_tick();
    check_lit("R5 half step", {32'd0, seg_lvl}, {32'd0, 32'h0});
    check("R5 model");

    // R7: mid-slot row write is deferred to the slot start
    write_reg(3'd4, 16'h0003);
    do_restart();
    write_reg(3'd4, 16'h0003);
    write_reg(3'd1, 16'h0000);
    for (int t = 0; t < 10; t++) do_tick();   // phase 2, slot 1
    s0 = seg_lvl;
    write_reg(3'd1, 16'hFFFF);
    check_lit("R7 no tear", {32'd0, seg_lvl}, {32'd0, s0});
    check("R7 model");
    for (int t = 0; t < 8; t++) begin do_tick(); check("R7 frame"); end

    // R6: display off applies at next slot
    do_tick();                                 // phase 3
    write_reg(3'd4, 16'h0002);
    check("R6 still on");
    do_tick();
    check("R6 off at slot");
    check_lit("R6 com nonselect", {56'd0, com_lvl}, {56'd0, 8'h55});

    // R11: bias change waits for frame wrap
    write_reg(3'd4, 16'h0001);
    for (int t = 0; t < 12; t++) begin do_tick(); check("R11 bias switch"); end

    // R9: per-pin select, low bits ignored
    write_reg(3'd5, 16'h0000);
    check_lit("R9 sel clear", {48'd0, seg_en}, {48'd0, 16'h000F});
    write_reg(3'd5, 16'hA5A0);
    check_lit("R9 sel pattern", {48'd0, seg_en}, {48'd0, 16'hA5AF});
    check("R9 model");
    do_tick(); check("R9 tick");

    // R8: panel off releases every pin
    write_reg(3'd4, 16'h0005);
    check_lit("R8 off", {seg_lvl, com_lvl, 4'd0, com_en, seg_en}, 64'd0);
    do_tick(); check("R8 model");
    write_reg(3'd4, 16'h0001);
    check("R8 back on");

    // R10: restart clears display-on and phase
    for (int t = 0; t < 5; t++) do_tick();
    do_restart();
    check("R10 restart");
    check_lit("R10 com", {56'd0, com_lvl}, {56'd0, 8'h55});
    for (int t = 0; t < 8; t++) begin do_tick(); check("R10 after"); end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule